// File: doc/BRIEF.md
# Nearest-Ratio Clock Divider Calculator

This block works out the 8-bit integer divide factor that brings a parent clock frequency as close as possible to a requested output frequency. It rounds to the nearest achievable frequency instead of truncating. When two candidate factors miss the target by the same amount, it takes the larger factor. It limits the factor to the range 1 to 255 and sets a flag whenever it has to clamp. A second mode takes a factor that software read back from a divider register and reports the frequency that factor produces. A factor of zero means the clock is gated off, so the reported frequency is zero.

Frequencies are unsigned integers in any common unit. One sequential restoring divider does all the arithmetic. It produces one quotient bit per cycle, and a compute request uses the divider up to three times in a row. The caller pulses the start input with the operands held steady for that cycle. It then waits for the one-cycle done pulse. The results stay on the outputs until the next accepted request finishes.

Top module: `clkdiv_ratio_calc`

## Requirements
- R1: In compute mode (`mode_i` = 0), with d = parent/target (truncated) and 1 <= d <= 255, the result is d or d+1, whichever gives the smaller |target − parent/factor|.
- R2: When d and d+1 give equal error, the result is d+1 (ties go to the larger divisor).
- R3: If the chosen factor would exceed 255, including the case d = 255 rounding up to 256, `factor_o` is 255 and `ovf_o` is 1.
- R4: A target of zero is treated as overflow: `factor_o` = 255 and `ovf_o` = 1.
- R5: If the target exceeds the parent (d = 0), `factor_o` = 1, `udf_o` = 1 and `freq_o` = parent.
- R6: In readback mode (`mode_i` = 1), `factor_i` = 0 gives `freq_o` = 0 and `factor_o` = 0, with both flags clear.
- R7: In readback mode, a nonzero `factor_i` gives `freq_o` = parent / `factor_i` (truncated) and `factor_o` = `factor_i`.
- R8: In compute mode, `freq_o` equals parent / `factor_o` (truncated). `ovf_o` and `udf_o` are never set together.
- R9: Each accepted start produces exactly one `done_o` pulse, one cycle wide. `busy_o` is high from the cycle after acceptance through the done cycle.
- R10: A start pulse while `busy_o` is high is ignored. The running request completes with its own operands, and no extra done pulse follows.
- R11: After reset, `done_o`, `busy_o`, `ovf_o` and `udf_o` are 0, and `factor_o` and `freq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request strobe, sampled while idle |
| mode_i | input | 1 | 0 = compute factor, 1 = report frequency of `factor_i` |
| parent_i | input | 32 | Parent clock frequency |
| target_i | input | 32 | Requested output frequency (compute mode) |
| factor_i | input | 8 | Factor read back from a divider register (readback mode) |
| factor_o | output | 8 | Chosen or echoed divide factor |
| freq_o | output | 32 | Frequency produced by `factor_o` |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Request in progress |
| ovf_o | output | 1 | Factor clamped to 255 |
| udf_o | output | 1 | Factor forced to 1 |

## Verification
An internal fault shows up at the ports at the done pulse of the request that hits it. A wrong quotient bit or a stale saved quotient gives a factor off by one, or a `freq_o` that does not equal parent/`factor_o`. A wrong range decision shows as a missing or extra clamp flag. A control sequence that stalls never raises `done_o` within the few hundred cycles that three divisions need. A lost busy guard shows as a second done pulse, or as results taken from the later operands. Directed cases cover exact ratios, rounding both ways, an exact tie, the 255/256 edge, a zero target, a target above the parent, both readback cases and a start pulse during a run. A short deterministic sweep is compared against a reference model computed in the bench.

// File: rtl/clkdiv_calc_pkg.sv
// Shared types for the nearest-ratio divider calculator.
// Assumes: factor width and data width are set at the top level.
package clkdiv_calc_pkg;

    // Control sequence states
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a request
        ST_QUO,    // parent / target in flight
        ST_LO,     // parent / d in flight
        ST_HI,     // parent / (d+1) in flight
        ST_FIN,    // parent / final factor in flight
        ST_DONE    // results valid, done pulse
    } calc_state_t;

    localparam logic MODE_COMPUTE  = 1'b0;
    localparam logic MODE_READBACK = 1'b1;

endpackage

// File: rtl/seq_divider.sv
// Sequential restoring unsigned divider.
// Produces one quotient bit per cycle over W cycles after start_i is
// sampled, then pulses done_o for one cycle with quot_o valid.
// Assumes: divisor_i is nonzero; start_i is ignored while running.
module seq_divider #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic [W-1:0] quot_o,
    output logic         done_o
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  div_q;
    logic [W-1:0]  dvd_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;
    logic [W:0]    shifted;
    logic [W:0]    diff;
    logic          fits;

    // Trial subtraction of the divisor from the shifted partial remainder
    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        diff    = shifted - {1'b0, div_q};
        fits    = (shifted >= {1'b0, div_q});
    end

    // Load operands, then step one quotient bit per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            div_q  <= '0;
            dvd_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i && cnt_q == '0) begin
                rem_q <= '0;
                quo_q <= dividend_i;
                div_q <= divisor_i;
                dvd_q <= dividend_i;
                cnt_q <= CW'(W);
            end else if (cnt_q != '0) begin
                if (fits) begin
                    rem_q <= diff[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= shifted[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign quot_o = quo_q;
    assign done_o = done_q;

    // R7: finished quotient and remainder reconstruct the dividend
    a_r7_div_identity: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (({{W{1'b0}}, quo_q} * {{W{1'b0}}, div_q}) + {{W{1'b0}}, rem_q}
                    == {{W{1'b0}}, dvd_q}) && (rem_q < div_q));

    // R9: divider completion is a single-cycle pulse
    a_r9_div_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

endmodule

// File: rtl/nearest_pick.sv
// Chooses between divisor d and d+1 by smaller frequency error, with ties
// going to d+1, then clamps the result to the factor range.
// Assumes: 1 <= base_i <= 2**FW-1; q_lo_i = parent/base_i and
// q_hi_i = parent/(base_i+1).
module nearest_pick #(
    parameter int W  = 32,
    parameter int FW = 8
) (
    input  logic [W-1:0]  target_i,
    input  logic [FW:0]   base_i,
    input  logic [W-1:0]  q_lo_i,
    input  logic [W-1:0]  q_hi_i,
    output logic [FW-1:0] factor_o,
    output logic [W-1:0]  freq_o,
    output logic          ovf_o
);
    localparam int FMAX = (1 << FW) - 1;

    logic [W-1:0] err_lo;
    logic [W-1:0] err_hi;
    logic         take_hi;
    logic [FW:0]  cand;

    // Absolute error of each candidate against the target
    always_comb begin
        err_lo  = (target_i >= q_lo_i) ? (target_i - q_lo_i) : (q_lo_i - target_i);
        err_hi  = (target_i >= q_hi_i) ? (target_i - q_hi_i) : (q_hi_i - target_i);
        take_hi = (err_hi <= err_lo);
        cand    = take_hi ? (base_i + (FW+1)'(1)) : base_i;
    end

    // Clamp; a clamp here means base was FMAX, so q_lo is parent/FMAX
    always_comb begin
        if (cand > (FW+1)'(FMAX)) begin
            factor_o = FW'(FMAX);
            freq_o   = q_lo_i;
            ovf_o    = 1'b1;
        end else begin
            factor_o = cand[FW-1:0];
            freq_o   = take_hi ? q_hi_i : q_lo_i;
            ovf_o    = 1'b0;
        end
    end

endmodule

// File: rtl/clkdiv_ratio_calc.sv
// Nearest-ratio clock divider calculator, top level.
// Compute mode: finds the factor in 1..2**FW-1 whose parent/factor is
// nearest the target, ties to the larger factor, with clamp flags.
// Readback mode: reports parent/factor, or 0 for a gated (zero) factor.
// Assumes: operands are valid in the cycle start_i is high while idle.
module clkdiv_ratio_calc
    import clkdiv_calc_pkg::*;
#(
    parameter int W  = 32,
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          mode_i,
    input  logic [W-1:0]  parent_i,
    input  logic [W-1:0]  target_i,
    input  logic [FW-1:0] factor_i,
    output logic [FW-1:0] factor_o,
    output logic [W-1:0]  freq_o,
    output logic          done_o,
    output logic          busy_o,
    output logic          ovf_o,
    output logic          udf_o
);
    localparam int FMAX = (1 << FW) - 1;

    calc_state_t   state_q;
    logic          mode_q;
    logic [W-1:0]  parent_q;
    logic [W-1:0]  target_q;
    logic [FW:0]   base_q;
    logic [W-1:0]  q_lo_q;
    logic [FW-1:0] factor_q;
    logic [W-1:0]  freq_q;
    logic          ovf_q;
    logic          udf_q;
    logic          dstart_q;
    logic [W-1:0]  divisor_q;

    logic [W-1:0]  div_quot;
    logic          div_done;
    logic [FW-1:0] pick_factor;
    logic [W-1:0]  pick_freq;
    logic          pick_ovf;

    seq_divider #(.W(W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (dstart_q),
        .dividend_i (parent_q),
        .divisor_i  (divisor_q),
        .quot_o     (div_quot),
        .done_o     (div_done)
    );

    nearest_pick #(.W(W), .FW(FW)) u_pick (
        .target_i (target_q),
        .base_i   (base_q),
        .q_lo_i   (q_lo_q),
        .q_hi_i   (div_quot),
        .factor_o (pick_factor),
        .freq_o   (pick_freq),
        .ovf_o    (pick_ovf)
    );

    // Request sequencing: capture, chain divisions, latch results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            mode_q    <= MODE_COMPUTE;
            parent_q  <= '0;
            target_q  <= '0;
            base_q    <= '0;
            q_lo_q    <= '0;
            factor_q  <= '0;
            freq_q    <= '0;
            ovf_q     <= 1'b0;
            udf_q     <= 1'b0;
            dstart_q  <= 1'b0;
            divisor_q <= '0;
        end else begin
            dstart_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        mode_q   <= mode_i;
                        parent_q <= parent_i;
                        target_q <= target_i;
                        ovf_q    <= 1'b0;
                        udf_q    <= 1'b0;
                        if (mode_i == MODE_READBACK) begin
                            factor_q <= factor_i;
                            if (factor_i == '0) begin
                                freq_q  <= '0;
                                state_q <= ST_DONE;
                            end else begin
                                divisor_q <= W'(factor_i);
                                dstart_q  <= 1'b1;
                                state_q   <= ST_FIN;
                            end
                        end else if (target_i == '0) begin
                            factor_q  <= FW'(FMAX);
                            ovf_q     <= 1'b1;
                            divisor_q <= W'(FMAX);
                            dstart_q  <= 1'b1;
                            state_q   <= ST_FIN;
                        end else begin
                            divisor_q <= target_i;
                            dstart_q  <= 1'b1;
                            state_q   <= ST_QUO;
                        end
                    end
                end
                ST_QUO: begin
                    if (div_done) begin
                        if (div_quot == '0) begin
                            factor_q <= FW'(1);
                            udf_q    <= 1'b1;
                            freq_q   <= parent_q;
                            state_q  <= ST_DONE;
                        end else if (|div_quot[W-1:FW]) begin
                            factor_q  <= FW'(FMAX);
                            ovf_q     <= 1'b1;
                            divisor_q <= W'(FMAX);
                            dstart_q  <= 1'b1;
                            state_q   <= ST_FIN;
                        end else begin
                            base_q    <= {1'b0, div_quot[FW-1:0]};
                            divisor_q <= div_quot;
                            dstart_q  <= 1'b1;
                            state_q   <= ST_LO;
                        end
                    end
                end
                ST_LO: begin
                    if (div_done) begin
                        q_lo_q    <= div_quot;
                        divisor_q <= {{(W-FW-1){1'b0}}, base_q} + W'(1);
                        dstart_q  <= 1'b1;
                        state_q   <= ST_HI;
                    end
                end
                ST_HI: begin
                    if (div_done) begin
                        factor_q <= pick_factor;
                        freq_q   <= pick_freq;
                        ovf_q    <= pick_ovf;
                        state_q  <= ST_DONE;
                    end
                end
                ST_FIN: begin
                    if (div_done) begin
                        freq_q  <= div_quot;
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign factor_o = factor_q;
    assign freq_o   = freq_q;
    assign ovf_o    = ovf_q;
    assign udf_o    = udf_q;
    assign done_o   = (state_q == ST_DONE);
    assign busy_o   = (state_q != ST_IDLE);

    // R9: done is a single-cycle pulse
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3: overflow always reports the maximum factor
    a_r3_ovf_max: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ovf_o) |-> (factor_o == FW'(FMAX)));

    // R5: underflow reports factor 1 and the parent frequency
    a_r5_udf_one: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && udf_o) |-> (factor_o == FW'(1) && freq_o == parent_q));

    // R6: a gated readback factor reports zero frequency
    a_r6_gated_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mode_q == MODE_READBACK && factor_o == '0) |-> (freq_o == '0));

    // R8: the two clamp flags are exclusive
    a_r8_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(ovf_o && udf_o));

    // R10: captured operands stay put while a request runs
    a_r10_hold_operands: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(parent_q) && $stable(target_q)));

    // R7: the divider is never launched with a zero divisor
    a_r7_divisor_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        dstart_q |-> (divisor_q != '0));

endmodule

// File: tb/clkdiv_ratio_calc_test.sv
// Directed bench for the nearest-ratio divider calculator.
module clkdiv_ratio_calc_test;
    localparam int CLK_PERIOD = 10;
    localparam int OP_TIMEOUT = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [31:0] parent_i = '0;
    logic [31:0] target_i = '0;
    logic [7:0]  factor_i = '0;
    logic [7:0]  factor_o;
    logic [31:0] freq_o;
    logic        done_o;
    logic        busy_o;
    logic        ovf_o;
    logic        udf_o;

    int errors = 0;
    int checks = 0;

    logic [7:0]  got_f;
    logic [31:0] got_fr;
    logic        got_o;
    logic        got_u;
    bit          got_done;

    clkdiv_ratio_calc uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .parent_i(parent_i), .target_i(target_i), .factor_i(factor_i),
        .factor_o(factor_o), .freq_o(freq_o), .done_o(done_o),
        .busy_o(busy_o), .ovf_o(ovf_o), .udf_o(udf_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model built from the requirements
    function automatic void ref_compute(input longint unsigned p, input longint unsigned t,
                                        output longint unsigned f, output longint unsigned fr,
                                        output bit o, output bit u);
        longint unsigned d, lo, hi, elo, ehi, r;
        o = 0; u = 0;
        if (t == 0) begin f = 255; o = 1; fr = p / 255; return; end
        d = p / t;
        if (d == 0) begin f = 1; u = 1; fr = p; return; end
        if (d > 255) begin f = 255; o = 1; fr = p / 255; return; end
        lo = p / d; hi = p / (d + 1);
        elo = (t > lo) ? t - lo : lo - t;
        ehi = (t > hi) ? t - hi : hi - t;
        r = (ehi <= elo) ? d + 1 : d;
        if (r > 255) begin f = 255; o = 1; fr = p / 255; end
        else begin f = r; fr = p / r; end
    endfunction

    // Issue one request and wait for its done pulse; check pulse width
    task automatic run_op(input logic m, input logic [31:0] p, input logic [31:0] t,
                          input logic [7:0] fi);
        @(negedge clk);
        mode_i = m; parent_i = p; target_i = t; factor_i = fi; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        got_done = 0;
        for (int i = 0; i < OP_TIMEOUT; i++) begin
            if (done_o) begin got_done = 1; break; end
            @(negedge clk);
        end
        got_f = factor_o; got_fr = freq_o; got_o = ovf_o; got_u = udf_o;
        check(got_done, "R9 done arrives", got_done, 1);
        @(negedge clk);
        check(!done_o, "R9 done one cycle wide", done_o, 0);
    endtask

    task automatic check_compute(input logic [31:0] p, input logic [31:0] t, input string req);
        longint unsigned ef, efr;
        bit eo, eu;
        ref_compute(p, t, ef, efr, eo, eu);
        run_op(1'b0, p, t, 8'd0);
        check(got_f == ef, {req, " factor"}, got_f, ef);
        check(got_fr == efr, {req, " freq (R8)"}, got_fr, efr);
        check(got_o == eo && got_u == eu, {req, " flags"}, {got_o, got_u}, {eo, eu});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!done_o && !busy_o && !ovf_o && !udf_o, "R11 reset controls", {done_o, busy_o, ovf_o, udf_o}, 0);
        check(factor_o == 0 && freq_o == 0, "R11 reset data", freq_o, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_nearest();
        check_compute(32'd800000000, 32'd200000000, "R1 exact ratio");
        run_op(1'b0, 32'd100, 32'd23, 8'd0);
        check(got_f == 8'd4 && got_fr == 32'd25, "R1 keep lower divisor", got_f, 4);
        run_op(1'b0, 32'd100, 32'd22, 8'd0);
        check(got_f == 8'd5 && got_fr == 32'd20, "R1 round up divisor", got_f, 5);
    endtask

    task automatic t_tie();
        run_op(1'b0, 32'd120, 32'd50, 8'd0);
        check(got_f == 8'd3 && got_fr == 32'd40, "R2 tie to larger divisor", got_f, 3);
    endtask

    task automatic t_overflow();
        run_op(1'b0, 32'd1000, 32'd3, 8'd0);
        check(got_f == 8'd255 && got_o && !got_u, "R3 large quotient clamps", got_f, 255);
        check(got_fr == 32'd3, "R3 clamped freq", got_fr, 3);
        run_op(1'b0, 32'd65535, 32'd256, 8'd0);
        check(got_f == 8'd255 && got_o && got_fr == 32'd257, "R3 255 rounding to 256 clamps", got_fr, 257);
        run_op(1'b0, 32'd511, 32'd2, 8'd0);
        check(got_f == 8'd255 && !got_o, "R3 255 exact no flag", got_o, 0);
    endtask

    task automatic t_zero_target();
        run_op(1'b0, 32'd1000, 32'd0, 8'd0);
        check(got_f == 8'd255 && got_o && !got_u, "R4 zero target overflow", got_f, 255);
    endtask

    task automatic t_underflow();
        run_op(1'b0, 32'd100, 32'd500, 8'd0);
        check(got_f == 8'd1 && got_u && !got_o, "R5 target above parent", got_f, 1);
        check(got_fr == 32'd100, "R5 freq equals parent", got_fr, 100);
    endtask

    task automatic t_readback();
        run_op(1'b1, 32'd100, 32'd0, 8'd0);
        check(got_fr == 0 && got_f == 0 && !got_o && !got_u, "R6 gated factor", got_fr, 0);
        run_op(1'b1, 32'd100, 32'd0, 8'd7);
        check(got_fr == 32'd14 && got_f == 8'd7, "R7 readback seven", got_fr, 14);
        run_op(1'b1, 32'd800000000, 32'd0, 8'd255);
        check(got_fr == 32'd3137254, "R7 readback max", got_fr, 3137254);
    endtask

    task automatic t_busy_ignore();
        int extra;
        bit seen;
        @(negedge clk);
        mode_i = 1'b0; parent_i = 32'd800000000; target_i = 32'd200000000; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        check(busy_o, "R9 busy during run", busy_o, 1);
        parent_i = 32'd90; target_i = 32'd7; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        seen = 0;
        for (int i = 0; i < OP_TIMEOUT; i++) begin
            if (done_o) begin seen = 1; break; end
            @(negedge clk);
        end
        check(seen && factor_o == 8'd4 && freq_o == 32'd200000000, "R10 first request kept", freq_o, 200000000);
        extra = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (done_o) extra++;
        end
        check(extra == 0 && !busy_o, "R10 no second done", extra, 0);
    endtask

    task automatic t_sweep();
        for (int i = 1; i <= 8; i++) begin
            logic [31:0] p, t;
            p = 32'(1000 + i * 9973 * 131);
            t = 32'(i * i * 613 + 17);
            check_compute(p, t, "R1 sweep");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_nearest();
        t_tie();
        t_overflow();
        t_zero_target();
        t_underflow();
        t_readback();
        t_busy_ignore();
        t_sweep();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule